// File: doc/BRIEF.md
# Register Type-Tag Tracker and Unit Steering

This block keeps a one-bit type tag for every architectural register. A tag of 1 means the register holds a floating-point value. A tag of 0 means it holds anything else: an integer, an address and so on. The tags are held apart from the register data. They are updated as decoded instructions retire through decode. Floating-point loads set the destination tag. Other loads clear it. Result-writing operations tag their destination with the domain of the unit that produced the result.

The tags let a single opcode be shared between the integer and floating-point domains. For such a shared operation, the tag of the source register picks the functional unit, and the steer decision comes out registered one cycle after the instruction is presented. On procedure entry the whole tag vector is sent out as one word to be saved. On exit the block waits for that word to come back from the load/store path.

While the restore is outstanding, decode is held only for instructions whose outcome depends on tags. Tags written after the exit but before the restore lands keep their newer values. A write by one instruction is forwarded to the instruction right behind it, and a restore word is forwarded to a tag read made in the cycle it arrives.

Top module: `regtag_steer`

## Requirements
- R1: After reset every tag is 0; an entry save issued first produces an all-zero word.
- R2: A floating-point load (class 1) sets the destination tag to 1; an integer load (class 2) clears it to 0; loads produce no steer output.
- R3: An integer-only operation (class 3) is steered to the integer unit and writes tag 0; a floating-point-only operation (class 4) is steered to the floating-point unit and writes tag 1.
- R4: A shared operation (class 5) goes to the floating-point unit when its source tag is 1 and to the integer unit when it is 0, and writes that same domain into its destination tag.
- R5: Steer outputs are registered, one cycle after an accepted instruction; when steer_valid_o is 1 exactly one of to_fpu_o and to_int_o is 1, otherwise both are 0.
- R6: A tag written by one instruction is seen by a tag read in the very next cycle.
- R7: An entry instruction (class 6) yields save_valid_o one cycle later with save_data_o bit i equal to the tag of register i.
- R8: An exit instruction (class 7) opens a restore; the restore word (rest_valid_i high) then replaces the tags, with bit i going to register i.
- R9: While a restore is open and rest_valid_i is low, classes 5, 6 and 7 assert stall_o and are not accepted; other classes are not stalled; a restore arriving in the same cycle removes the stall and is forwarded to the read.
- R10: A tag written after an exit is accepted and before its restore lands keeps the written value over the restored bit.
- R11: rest_valid_i with no restore open has no effect on the tags.
- R12: Class 0 and any cycle with dec_valid_i low change no tag and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decoded instruction present |
| dec_class_i | input | 3 | Instruction class: 0 none, 1 fp load, 2 int load, 3 int op, 4 fp op, 5 shared op, 6 entry, 7 exit |
| dec_src_i | input | 5 | Source register index |
| dec_dst_i | input | 5 | Destination register index |
| rest_valid_i | input | 1 | Restore word valid |
| rest_data_i | input | 32 | Restore word, bit i for register i |
| stall_o | output | 1 | Hold the current decode instruction |
| steer_valid_o | output | 1 | Registered dispatch decision valid |
| to_fpu_o | output | 1 | Dispatch to floating-point unit |
| to_int_o | output | 1 | Dispatch to integer unit |
| save_valid_o | output | 1 | Tag save word valid |
| save_data_o | output | 32 | Tag save word |

## Verification
The tags are loaded with several irregular bit patterns by loads of both kinds. Each pattern is then read back both through entry saves and through a shared operation on every register. This separates a wrong bit position from a wrong polarity or a stuck steer. Back-to-back write-then-read pairs on the same register tell forwarding apart from a read of the stale array. Exit sequences are run with restore words arriving late, arriving in the same cycle as a stalled class, and interleaved with post-exit writes. These distinguish a missing stall, a stall that is too broad, a restore that overwrites newer tags, and a restore that is wrongly taken when none is open.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_LD_FP  = 3'd1,
    CLS_LD_INT = 3'd2,
    CLS_OP_INT = 3'd3,
    CLS_OP_FP  = 3'd4,
    CLS_OP_SHR = 3'd5,
    CLS_ENTER  = 3'd6,
    CLS_EXIT   = 3'd7
  } instr_cls_e;

  typedef struct packed {
    logic steer;     // dispatched to a functional unit
    logic fixed_fp;  // unit fixed to fp when not shared
    logic shared;    // unit chosen by source tag
    logic wr;        // writes destination tag
    logic wr_val;    // constant tag value when not shared
    logic needs_tag; // outcome depends on tag state
    logic save;
    logic exit;
  } dec_ctl_t;
endpackage

// File: rtl/regtag_decode.sv
module regtag_decode
  import regtag_pkg::*;
(
  input  logic [2:0] cls_i,
  output dec_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (instr_cls_e'(cls_i))
      CLS_LD_FP:  begin ctl_o.wr = 1'b1; ctl_o.wr_val = 1'b1; end
      CLS_LD_INT: begin ctl_o.wr = 1'b1; ctl_o.wr_val = 1'b0; end
      CLS_OP_INT: begin ctl_o.steer = 1'b1; ctl_o.wr = 1'b1; end
      CLS_OP_FP:  begin
        ctl_o.steer = 1'b1; ctl_o.fixed_fp = 1'b1;
        ctl_o.wr = 1'b1; ctl_o.wr_val = 1'b1;
      end
      CLS_OP_SHR: begin
        ctl_o.steer = 1'b1; ctl_o.shared = 1'b1;
        ctl_o.wr = 1'b1; ctl_o.needs_tag = 1'b1;
      end
      CLS_ENTER:  begin ctl_o.save = 1'b1; ctl_o.needs_tag = 1'b1; end
      CLS_EXIT:   begin ctl_o.exit = 1'b1; ctl_o.needs_tag = 1'b1; end
      default:    ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/regtag_restore.sv
module regtag_restore (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exit_acc_i,
  input  logic rest_valid_i,
  output logic pend_o,
  output logic apply_o
);
  logic pend_q;

  assign pend_o  = pend_q;
  assign apply_o = pend_q & rest_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (exit_acc_i) pend_q <= 1'b1;
    else if (apply_o)    pend_q <= 1'b0;
  end
endmodule

// File: rtl/regtag_file.sv
module regtag_file #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_val_i,
  input  logic                pend_i,
  input  logic                apply_i,
  input  logic                clr_dirty_i,
  input  logic [NUM_REGS-1:0] rest_data_i,
  output logic [NUM_REGS-1:0] view_o
);
  logic [NUM_REGS-1:0] tags_q, dirty_q, eff, wr_mask;
  logic                wr_v_q, wr_val_q;
  logic [IDX_W-1:0]    wr_idx_q;

  // pending write forwarded into the read view
  always_comb begin
    eff = tags_q;
    if (wr_v_q) eff[wr_idx_q] = wr_val_q;
  end

  // bits written after exit win over the restore word
  assign view_o  = apply_i ? ((rest_data_i & ~dirty_q) | (eff & dirty_q)) : eff;
  assign wr_mask = {{(NUM_REGS-1){1'b0}}, 1'b1} << wr_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q   <= '0;
      dirty_q  <= '0;
      wr_v_q   <= 1'b0;
      wr_idx_q <= '0;
      wr_val_q <= 1'b0;
    end else begin
      tags_q   <= view_o;
      wr_v_q   <= wr_en_i;
      wr_idx_q <= wr_idx_i;
      wr_val_q <= wr_val_i;
      if (clr_dirty_i || apply_i)  dirty_q <= '0;
      else if (wr_en_i && pend_i)  dirty_q <= dirty_q | wr_mask;
    end
  end
endmodule

// File: rtl/regtag_steer.sv
module regtag_steer
  import regtag_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dec_valid_i,
  input  logic [2:0]          dec_class_i,
  input  logic [IDX_W-1:0]    dec_src_i,
  input  logic [IDX_W-1:0]    dec_dst_i,
  input  logic                rest_valid_i,
  input  logic [NUM_REGS-1:0] rest_data_i,
  output logic                stall_o,
  output logic                steer_valid_o,
  output logic                to_fpu_o,
  output logic                to_int_o,
  output logic                save_valid_o,
  output logic [NUM_REGS-1:0] save_data_o
);
  dec_ctl_t            ctl;
  logic                pend, apply, acc, src_tag, use_fp, wr_val;
  logic [NUM_REGS-1:0] view;
  logic                stv_q, fp_q, int_q, sv_q;
  logic [NUM_REGS-1:0] sd_q;

  regtag_decode u_dec (.cls_i(dec_class_i), .ctl_o(ctl));

  regtag_restore u_rst (
    .clk_i, .rst_ni,
    .exit_acc_i  (acc & ctl.exit),
    .rest_valid_i,
    .pend_o      (pend),
    .apply_o     (apply)
  );

  regtag_file #(.NUM_REGS(NUM_REGS)) u_file (
    .clk_i, .rst_ni,
    .wr_en_i     (acc & ctl.wr),
    .wr_idx_i    (dec_dst_i),
    .wr_val_i    (wr_val),
    .pend_i      (pend),
    .apply_i     (apply),
    .clr_dirty_i (acc & ctl.exit),
    .rest_data_i,
    .view_o      (view)
  );

  assign stall_o = dec_valid_i & ctl.needs_tag & pend & ~rest_valid_i;
  assign acc     = dec_valid_i & ~stall_o;
  assign src_tag = view[dec_src_i];
  assign use_fp  = ctl.shared ? src_tag : ctl.fixed_fp;
  assign wr_val  = ctl.shared ? src_tag : ctl.wr_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stv_q <= 1'b0;
      fp_q  <= 1'b0;
      int_q <= 1'b0;
      sv_q  <= 1'b0;
      sd_q  <= '0;
    end else begin
      stv_q <= acc & ctl.steer;
      fp_q  <= acc & ctl.steer & use_fp;
      int_q <= acc & ctl.steer & ~use_fp;
      sv_q  <= acc & ctl.save;
      if (acc && ctl.save) sd_q <= view;
    end
  end

  assign steer_valid_o = stv_q;
  assign to_fpu_o      = fp_q;
  assign to_int_o      = int_q;
  assign save_valid_o  = sv_q;
  assign save_data_o   = sd_q;
endmodule

// File: rtl/regtag_steer_chk.sv
module regtag_steer_chk
  import regtag_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dec_valid_i,
  input logic [2:0] dec_class_i,
  input logic       rest_valid_i,
  input logic       stall_o,
  input logic       steer_valid_o,
  input logic       to_fpu_o,
  input logic       to_int_o,
  input logic       save_valid_o
);
  // R5
  steer_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_valid_o |-> $onehot({to_fpu_o, to_int_o}));
  // R5
  steer_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !steer_valid_o |-> !to_fpu_o && !to_int_o);
  // R9
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !steer_valid_o && !save_valid_o);
  // R9
  stall_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rest_valid_i |-> !stall_o);
  // R3
  fp_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && dec_class_i == CLS_OP_FP |=> steer_valid_o && to_fpu_o);
  // R3
  int_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && dec_class_i == CLS_OP_INT |=> steer_valid_o && to_int_o);
  // R2
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && (dec_class_i == CLS_LD_FP || dec_class_i == CLS_LD_INT) |=> !steer_valid_o);
  // R7
  enter_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && dec_class_i == CLS_ENTER && !stall_o |=> save_valid_o);
  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !steer_valid_o && !save_valid_o);
endmodule

bind regtag_steer regtag_steer_chk u_chk (
  .clk_i, .rst_ni, .dec_valid_i, .dec_class_i, .rest_valid_i,
  .stall_o, .steer_valid_o, .to_fpu_o, .to_int_o, .save_valid_o
);

// File: tb/sim_regtag_steer.sv
module sim_regtag_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic [2:0]  dec_class_i = '0;
  logic [4:0]  dec_src_i = '0, dec_dst_i = '0;
  logic        rest_valid_i = 1'b0;
  logic [31:0] rest_data_i = '0;
  logic        stall_o, steer_valid_o, to_fpu_o, to_int_o, save_valid_o;
  logic [31:0] save_data_o;

  int checks = 0, failures = 0;
  logic [31:0] tags_m = '0, dirty_m = '0;
  logic        pend_m = 1'b0;

  always #5 clk = ~clk;

  regtag_steer u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i, .dec_class_i, .dec_src_i, .dec_dst_i,
    .rest_valid_i, .rest_data_i, .stall_o, .steer_valid_o, .to_fpu_o, .to_int_o,
    .save_valid_o, .save_data_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_m(input int d, input logic v);
    tags_m[d] = v;
    if (pend_m) dirty_m[d] = 1'b1;
  endtask

  task automatic step(input string req, input logic v, input logic [2:0] c, input int s, input int d,
                      input logic rv = 1'b0, input logic [31:0] rdat = '0);
    logic [31:0] view;
    logic needs, xstall, acc, stv, fpu;
    view   = (pend_m && rv) ? ((rdat & ~dirty_m) | (tags_m & dirty_m)) : tags_m;
    needs  = (c == 3'd5) || (c == 3'd6) || (c == 3'd7);
    xstall = v && needs && pend_m && !rv;
    acc    = v && !xstall;
    dec_valid_i = v; dec_class_i = c; dec_src_i = 5'(s); dec_dst_i = 5'(d);
    rest_valid_i = rv; rest_data_i = rdat;
    #1;
    chk(req, "stall", 32'(stall_o), 32'(xstall));
    @(posedge clk); #1;
    stv = acc && (c == 3'd3 || c == 3'd4 || c == 3'd5);
    fpu = stv && (c == 3'd4 || (c == 3'd5 && view[s]));
    chk(req, "steer_valid", 32'(steer_valid_o), 32'(stv));
    chk(req, "to_fpu", 32'(to_fpu_o), 32'(fpu));
    chk(req, "to_int", 32'(to_int_o), 32'(stv && !fpu));
    chk(req, "save_valid", 32'(save_valid_o), 32'(acc && c == 3'd6));
    if (acc && c == 3'd6) chk(req, "save_data", save_data_o, view);
    if (pend_m && rv) begin tags_m = view; pend_m = 1'b0; dirty_m = '0; end
    if (acc) begin
      case (c)
        3'd1, 3'd4: wr_m(d, 1'b1);
        3'd2, 3'd3: wr_m(d, 1'b0);
        3'd5:       wr_m(d, view[s]);
        3'd7:       begin pend_m = 1'b1; dirty_m = '0; end
        default: ;
      endcase
    end
    dec_valid_i = 1'b0; rest_valid_i = 1'b0;
  endtask

  task automatic load_pattern(input logic [31:0] p);
    for (int r = 0; r < 32; r++) step("R2", 1'b1, p[r] ? 3'd1 : 3'd2, 0, r);
  endtask

  initial begin
    #(2_000_000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hA5C3_0F96; pats[1] = 32'h0000_0001;
    pats[2] = 32'h8000_0000; pats[3] = 32'h3C69_E2D5;
    #23 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset steer", {30'd0, to_fpu_o, to_int_o}, 32'd0);
    step("R1", 1'b1, 3'd6, 0, 0);
    // R2 R4 R7: patterns read back by save word and by shared op on every register
    for (int k = 0; k < 4; k++) begin
      load_pattern(pats[k]);
      step("R7", 1'b1, 3'd6, 0, 0);
      for (int r = 0; r < 32; r++) step("R4", 1'b1, 3'd5, r, 31 - r);
      step("R4", 1'b1, 3'd6, 0, 0);
    end
    // R3 fixed-domain ops
    for (int r = 0; r < 32; r += 3) step("R3", 1'b1, (r % 2) ? 3'd4 : 3'd3, r, r);
    step("R3", 1'b1, 3'd6, 0, 0);
    // R6 back-to-back forwarding
    for (int r = 0; r < 32; r++) begin
      step("R6", 1'b1, 3'd1, 0, r);
      step("R6", 1'b1, 3'd5, r, r);
      step("R6", 1'b1, 3'd2, 0, r);
      step("R6", 1'b1, 3'd5, r, (r + 1) % 32);
    end
    // R12 invalid or class 0 changes nothing
    step("R12", 1'b0, 3'd1, 0, 7);
    step("R12", 1'b1, 3'd0, 0, 7);
    step("R12", 1'b0, 3'd4, 0, 9);
    step("R12", 1'b1, 3'd6, 0, 0);
    // R11 restore with nothing open
    step("R11", 1'b0, 3'd0, 0, 0, 1'b1, 32'hFFFF_FFFF);
    step("R11", 1'b1, 3'd6, 0, 0);
    // R8 R9 R10 exit and restore
    for (int k = 0; k < 4; k++) begin
      step("R8", 1'b1, 3'd7, 0, 0);
      step("R9", 1'b1, 3'd5, k, k);
      step("R9", 1'b1, 3'd6, 0, 0);
      step("R9", 1'b1, 3'd7, 0, 0);
      step("R10", 1'b1, 3'd3, 0, 3 + k);
      step("R10", 1'b1, 3'd1, 0, 10 + k);
      step("R9", 1'b1, 3'd2, 0, 20 + k);
      if (k % 2 == 0) step("R9", 1'b1, 3'd5, 3 + k, 12, 1'b1, pats[k] ^ 32'hFFFF_0000);
      else begin
        step("R8", 1'b0, 3'd0, 0, 0, 1'b1, pats[k] ^ 32'h00FF_FF00);
        step("R8", 1'b1, 3'd5, 10 + k, 14);
      end
      step("R8", 1'b1, 3'd6, 0, 0);
    end
    // R9 exit accepted in the same cycle its predecessor restore lands
    step("R8", 1'b1, 3'd7, 0, 0);
    step("R9", 1'b1, 3'd7, 0, 0, 1'b1, 32'h1234_5678);
    step("R10", 1'b1, 3'd4, 0, 0);
    step("R8", 1'b0, 3'd0, 0, 0, 1'b1, 32'h0F0F_0F0E);
    step("R8", 1'b1, 3'd6, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule